// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device side of an ATA task file. The host reaches it through two address windows. The command block holds eight byte offsets: the data port and the parameter, drive, status and command registers. The control block holds only the alternate status register. The data port moves 16-bit words. Every other register moves single bytes. A 32-bit access to the data port becomes two 16-bit transfers on consecutive cycles: the low half first, then the high half.

The block does not run commands itself. It raises one-cycle action strobes for an external command state machine in four cases: when status is read through the command block, when the data port is used, when the command register is written, and when the drive-select register is written. The state machine loads the status and error registers through dedicated inputs. It presents the next read word on a data input. It collects each written word from a data output. A separate bus-master status byte records posted device interrupts.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, the status register reads 0x40 (device ready only), the error register reads 0x01, the bus-master status byte is 0x60, and the done, error and busy outputs and all strobes are 0.
- R2: Command-block byte offsets 2 (sector count), 3 (sector number), 4 (cylinder low), 5 (cylinder high) and 6 (drive/head) store a byte write and return it on a byte read. An access completes with `acc_done` one cycle after it is accepted.
- R3: A 16-bit access (size code 1) to command offset 0 reads the word on `data_in`, or places the write word on `data_wr`. Either way it pulses `act_data` for one cycle.
- R4: A 32-bit read (size code 2) of offset 0 takes two cycles. The first cycle captures `data_in` as the low half and pulses `act_data` while `busy` is high. The second cycle captures `data_in` again as the high half, pulses `act_data` again, and completes with the joined word.
- R5: A 32-bit write of offset 0 presents bits 15:0 on `data_wr` in the first cycle and bits 31:16 in the second. Each cycle pulses `act_data`.
- R6: A byte read of command offset 7 returns the status register and pulses `act_stat_rd`.
- R7: A byte read of control offset 6 (alternate status) returns the status register and raises no strobe.
- R8: A byte write to command offset 7 sets `cmd_o` and pulses `act_cmd`. A byte write to offset 6 pulses `act_drv_sel` and sets `drive_o`.
- R9: A byte write to command offset 1 (features) is discarded. A later read of offset 1 still returns the error register.
- R10: The following accesses are errors: any non-byte access to offsets 1 to 7, a byte access to offset 0, size code 3, any control-block offset other than 6, and any control-block write. An error pulses `acc_err` with `acc_done`, raises no strobe, returns 0 and changes no register.
- R11: `status_load` copies `status_in` into the status register. `err_load` copies `err_in` into the error register. Both take effect on the next clock edge.
- R12: `intr_post` sets bit 2 of `bm_status` (0x60 becomes 0x64). The bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request, taken when busy is low |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctrl | input | 1 | 1 = control block, 0 = command block |
| acc_off | input | 3 | Byte offset within the block |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with acc_done |
| acc_done | output | 1 | Access complete pulse |
| acc_err | output | 1 | Access rejected pulse |
| busy | output | 1 | Second half of a 32-bit data transfer pending |
| status_in | input | 8 | Status value from the command state machine |
| status_load | input | 1 | Load status_in |
| err_in | input | 8 | Error value from the command state machine |
| err_load | input | 1 | Load err_in |
| data_in | input | 16 | Word presented for data-port reads |
| data_wr | output | 16 | Last word written to the data port |
| intr_post | input | 1 | Device interrupt posted |
| bm_status | output | 8 | Bus-master status byte |
| cmd_o | output | 8 | Last command byte written |
| drive_o | output | 8 | Drive/head select register |
| act_stat_rd | output | 1 | Status read through command block |
| act_data | output | 1 | Data-port transfer |
| act_cmd | output | 1 | Command register written |
| act_drv_sel | output | 1 | Drive select written |

## Verification
The bench checks that the alternate status read leaves the strobes quiet while the offset-7 status read pulses one. A design that shared the two paths would wake the state machine on every poll. The 32-bit data read changes `data_in` between its halves. A design that sampled `data_in` once would return the same word twice, and one that swapped the halves would return them in the wrong order. The bench writes the features register, then writes a byte register with an illegal 16-bit access, and reads both back. A design that aliased features onto the error register, or that wrote despite the error, shows up as a changed byte.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        K_ERR,
        K_DATA16,
        K_DATA32,
        K_REG,
        K_ALT
    } acc_kind_e;

    localparam logic [2:0] OFF_DATA   = 3'd0;
    localparam logic [2:0] OFF_ERRFEA = 3'd1;
    localparam logic [2:0] OFF_SCNT   = 3'd2;
    localparam logic [2:0] OFF_SNUM   = 3'd3;
    localparam logic [2:0] OFF_CYLLO  = 3'd4;
    localparam logic [2:0] OFF_CYLHI  = 3'd5;
    localparam logic [2:0] OFF_DRIVE  = 3'd6;
    localparam logic [2:0] OFF_STACMD = 3'd7;

    typedef struct packed {
        logic [7:0]  scnt;
        logic [7:0]  snum;
        logic [7:0]  cyllo;
        logic [7:0]  cylhi;
        logic [7:0]  drive;
        logic [7:0]  cmd;
        logic [7:0]  errr;
        logic [7:0]  stat;
        logic        phase;
        logic        wr;
        logic [15:0] hold;
        logic [15:0] data_wr;
        logic [31:0] rdata;
        logic        done;
        logic        err;
        logic        s_stat;
        logic        s_data;
        logic        s_cmd;
        logic        s_drv;
    } tf_state_t;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter logic [2:0] ALT_OFF = 3'd6
) (
    input  logic            ctrl,
    input  logic            write,
    input  logic [2:0]      off,
    input  logic [1:0]      size,
    output acc_kind_e       kind
);
    always_comb begin
        kind = K_ERR;
        if (ctrl) begin
            if (!write && off == ALT_OFF && size == SZ_BYTE)
                kind = K_ALT;
        end else if (off == OFF_DATA) begin
            if (size == SZ_HALF)
                kind = K_DATA16;
            else if (size == SZ_WORD)
                kind = K_DATA32;
        end else if (size == SZ_BYTE) begin
            kind = K_REG;
        end
    end
endmodule

// File: rtl/ata_tf_bm_status.sv
module ata_tf_bm_status #(
    parameter int         BM_W     = 8,
    parameter int         INTR_BIT = 2,
    parameter logic [7:0] BM_RESET = 8'h60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            intr_post,
    output logic [BM_W-1:0] bm_q
);
    logic [BM_W-1:0] bm_d;

    always_comb begin
        bm_d = bm_q;
        if (intr_post)
            bm_d[INTR_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bm_q <= BM_RESET[BM_W-1:0];
        else
            bm_q <= bm_d;
    end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter logic [7:0] STAT_RESET = 8'h40,
    parameter logic [7:0] ERR_RESET  = 8'h01,
    parameter logic [7:0] BM_RESET   = 8'h60,
    parameter logic [2:0] ALT_OFF    = 3'd6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_ctrl,
    input  logic [2:0]  acc_off,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_done,
    output logic        acc_err,
    output logic        busy,
    input  logic [7:0]  status_in,
    input  logic        status_load,
    input  logic [7:0]  err_in,
    input  logic        err_load,
    input  logic [15:0] data_in,
    output logic [15:0] data_wr,
    input  logic        intr_post,
    output logic [7:0]  bm_status,
    output logic [7:0]  cmd_o,
    output logic [7:0]  drive_o,
    output logic        act_stat_rd,
    output logic        act_data,
    output logic        act_cmd,
    output logic        act_drv_sel
);
    localparam int HALF_W = 16;

    tf_state_t st_d, st_q;
    acc_kind_e kind;

    ata_tf_decode #(.ALT_OFF(ALT_OFF)) dec_i (
        .ctrl  (acc_ctrl),
        .write (acc_write),
        .off   (acc_off),
        .size  (acc_size),
        .kind  (kind)
    );

    ata_tf_bm_status #(.BM_W(8), .INTR_BIT(2), .BM_RESET(BM_RESET)) bm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .intr_post (intr_post),
        .bm_q      (bm_status)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.err    = 1'b0;
        st_d.s_stat = 1'b0;
        st_d.s_data = 1'b0;
        st_d.s_cmd  = 1'b0;
        st_d.s_drv  = 1'b0;

        if (st_q.phase) begin
            st_d.phase  = 1'b0;
            st_d.s_data = 1'b1;
            st_d.done   = 1'b1;
            if (st_q.wr)
                st_d.data_wr = st_q.hold;
            else
                st_d.rdata = {data_in, st_q.hold};
        end else if (acc_valid) begin
            st_d.rdata = '0;
            st_d.done  = 1'b1;
            st_d.wr    = acc_write;
            unique case (kind)
                K_ERR: st_d.err = 1'b1;
                K_DATA16: begin
                    st_d.s_data = 1'b1;
                    if (acc_write)
                        st_d.data_wr = acc_wdata[HALF_W-1:0];
                    else
                        st_d.rdata = {{HALF_W{1'b0}}, data_in};
                end
                K_DATA32: begin
                    st_d.s_data = 1'b1;
                    st_d.done   = 1'b0;
                    st_d.phase  = 1'b1;
                    if (acc_write) begin
                        st_d.data_wr = acc_wdata[HALF_W-1:0];
                        st_d.hold    = acc_wdata[2*HALF_W-1:HALF_W];
                    end else begin
                        st_d.hold = data_in;
                    end
                end
                K_ALT: st_d.rdata = {24'h0, st_q.stat};
                K_REG: begin
                    if (acc_write) begin
                        unique case (acc_off)
                            OFF_SCNT:   st_d.scnt  = acc_wdata[7:0];
                            OFF_SNUM:   st_d.snum  = acc_wdata[7:0];
                            OFF_CYLLO:  st_d.cyllo = acc_wdata[7:0];
                            OFF_CYLHI:  st_d.cylhi = acc_wdata[7:0];
                            OFF_DRIVE: begin
                                st_d.drive = acc_wdata[7:0];
                                st_d.s_drv = 1'b1;
                            end
                            OFF_STACMD: begin
                                st_d.cmd   = acc_wdata[7:0];
                                st_d.s_cmd = 1'b1;
                            end
                            default: ;
                        endcase
                    end else begin
                        unique case (acc_off)
                            OFF_ERRFEA: st_d.rdata = {24'h0, st_q.errr};
                            OFF_SCNT:   st_d.rdata = {24'h0, st_q.scnt};
                            OFF_SNUM:   st_d.rdata = {24'h0, st_q.snum};
                            OFF_CYLLO:  st_d.rdata = {24'h0, st_q.cyllo};
                            OFF_CYLHI:  st_d.rdata = {24'h0, st_q.cylhi};
                            OFF_DRIVE:  st_d.rdata = {24'h0, st_q.drive};
                            OFF_STACMD: begin
                                st_d.rdata  = {24'h0, st_q.stat};
                                st_d.s_stat = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                default: st_d.err = 1'b1;
            endcase
        end

        if (status_load)
            st_d.stat = status_in;
        if (err_load)
            st_d.errr = err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stat <= STAT_RESET;
            st_q.errr <= ERR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata   = st_q.rdata;
    assign acc_done    = st_q.done;
    assign acc_err     = st_q.err;
    assign busy        = st_q.phase;
    assign data_wr     = st_q.data_wr;
    assign cmd_o       = st_q.cmd;
    assign drive_o     = st_q.drive;
    assign act_stat_rd = st_q.s_stat;
    assign act_data    = st_q.s_data;
    assign act_cmd     = st_q.s_cmd;
    assign act_drv_sel = st_q.s_drv;
endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_done,
    input logic       acc_err,
    input logic       busy,
    input logic       intr_post,
    input logic [7:0] bm_status,
    input logic       act_stat_rd,
    input logic       act_data,
    input logic       act_cmd,
    input logic       act_drv_sel
);
    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_done && !act_stat_rd && !act_data && !act_cmd && !act_drv_sel);

    // R4
    split_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R4
    first_half_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> act_data && !acc_done);

    // R5
    second_half_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> act_data && acc_done);

    // R12
    intr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_post |=> bm_status[2]);

    // R12
    intr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_status[2] |=> bm_status[2]);

    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stat_rd, act_cmd, act_drv_sel}));
endmodule

bind ata_taskfile_regs ata_tf_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_done    (acc_done),
    .acc_err     (acc_err),
    .busy        (busy),
    .intr_post   (intr_post),
    .bm_status   (bm_status),
    .act_stat_rd (act_stat_rd),
    .act_data    (act_data),
    .act_cmd     (act_cmd),
    .act_drv_sel (act_drv_sel)
);

// File: tb/ata_taskfile_regs_tb_top.sv
module ata_taskfile_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ctrl = 1'b0;
    logic [2:0]  acc_off = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_done, acc_err, busy;
    logic [7:0]  status_in = '0, err_in = '0;
    logic        status_load = 1'b0, err_load = 1'b0, intr_post = 1'b0;
    logic [15:0] data_in = 16'hBEEF;
    logic [15:0] data_wr;
    logic [7:0]  bm_status, cmd_o, drive_o;
    logic        act_stat_rd, act_data, act_cmd, act_drv_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_ctrl(acc_ctrl),
        .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_done(acc_done), .acc_err(acc_err), .busy(busy),
        .status_in(status_in), .status_load(status_load),
        .err_in(err_in), .err_load(err_load),
        .data_in(data_in), .data_wr(data_wr),
        .intr_post(intr_post), .bm_status(bm_status),
        .cmd_o(cmd_o), .drive_o(drive_o),
        .act_stat_rd(act_stat_rd), .act_data(act_data),
        .act_cmd(act_cmd), .act_drv_sel(act_drv_sel)
    );

    // strobe field: {stat, data, cmd, drv}
    typedef struct packed {
        logic        wr;
        logic        ctrl;
        logic [2:0]  off;
        logic [1:0]  size;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic        exp_err;
        logic [3:0]  exp_stb;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd2, 2'd0, 16'h0011, 16'h0000, 1'b0, 4'b0000}, // R2
        '{1'b0, 1'b0, 3'd2, 2'd0, 16'h0000, 16'h0011, 1'b0, 4'b0000}, // R2
        '{1'b1, 1'b0, 3'd3, 2'd0, 16'h0022, 16'h0000, 1'b0, 4'b0000}, // R2
        '{1'b0, 1'b0, 3'd3, 2'd0, 16'h0000, 16'h0022, 1'b0, 4'b0000}, // R2
        '{1'b1, 1'b0, 3'd4, 2'd0, 16'h0033, 16'h0000, 1'b0, 4'b0000}, // R2
        '{1'b0, 1'b0, 3'd4, 2'd0, 16'h0000, 16'h0033, 1'b0, 4'b0000}, // R2
        '{1'b1, 1'b0, 3'd5, 2'd0, 16'h0044, 16'h0000, 1'b0, 4'b0000}, // R2
        '{1'b0, 1'b0, 3'd5, 2'd0, 16'h0000, 16'h0044, 1'b0, 4'b0000}, // R2
        '{1'b1, 1'b0, 3'd6, 2'd0, 16'h00A0, 16'h0000, 1'b0, 4'b0001}, // R8
        '{1'b0, 1'b0, 3'd6, 2'd0, 16'h0000, 16'h00A0, 1'b0, 4'b0000}, // R2
        '{1'b1, 1'b0, 3'd1, 2'd0, 16'h005A, 16'h0000, 1'b0, 4'b0000}, // R9
        '{1'b0, 1'b0, 3'd1, 2'd0, 16'h0000, 16'h0001, 1'b0, 4'b0000}, // R9
        '{1'b0, 1'b0, 3'd7, 2'd0, 16'h0000, 16'h0040, 1'b0, 4'b1000}, // R6
        '{1'b0, 1'b1, 3'd6, 2'd0, 16'h0000, 16'h0040, 1'b0, 4'b0000}, // R7
        '{1'b0, 1'b0, 3'd0, 2'd1, 16'h0000, 16'hBEEF, 1'b0, 4'b0100}, // R3
        '{1'b1, 1'b0, 3'd0, 2'd1, 16'h1234, 16'h0000, 1'b0, 4'b0100}, // R3
        '{1'b1, 1'b0, 3'd7, 2'd0, 16'h00EC, 16'h0000, 1'b0, 4'b0010}, // R8
        '{1'b0, 1'b0, 3'd2, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b0, 1'b0, 3'd0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b0, 1'b0, 3'd3, 2'd3, 16'h0000, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b0, 1'b1, 3'd2, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b1, 1'b1, 3'd6, 2'd0, 16'h00FF, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b1, 1'b0, 3'd2, 2'd1, 16'hFFFF, 16'h0000, 1'b1, 4'b0000}, // R10
        '{1'b0, 1'b0, 3'd2, 2'd0, 16'h0000, 16'h0011, 1'b0, 4'b0000}, // R10
        '{1'b0, 1'b0, 3'd7, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'b0000}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, accept at next posedge, return at the following negedge
    task automatic access(input logic wr, input logic ctl, input logic [2:0] off,
                          input logic [1:0] sz, input logic [31:0] wd);
        acc_valid = 1'b1; acc_write = wr; acc_ctrl = ctl;
        acc_off = off; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [3:0] stb();
        return {act_stat_rd, act_data, act_cmd, act_drv_sel};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 bm", {24'h0, bm_status}, 32'h60);
        check("R1 flags", {28'h0, acc_done, acc_err, busy, 1'b0}, 32'h0);
        check("R1 strobes", {28'h0, stb()}, 32'h0);
        access(1'b0, 1'b0, 3'd7, 2'd0, 32'h0);
        check("R1 status", acc_rdata, 32'h40);
        access(1'b0, 1'b0, 3'd1, 2'd0, 32'h0);
        check("R1 error", acc_rdata, 32'h01);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].ctrl, VECS[i].off, VECS[i].size,
                   {16'h0, VECS[i].wdata});
            check($sformatf("vec%0d done", i), {31'h0, acc_done}, 32'h1);
            check($sformatf("vec%0d err", i), {31'h0, acc_err}, {31'h0, VECS[i].exp_err});
            check($sformatf("vec%0d rd", i), acc_rdata, {16'h0, VECS[i].exp_rd});
            check($sformatf("vec%0d stb", i), {28'h0, stb()}, {28'h0, VECS[i].exp_stb});
        end
        check("R3 data_wr", {16'h0, data_wr}, 32'h1234);
        check("R8 cmd_o", {24'h0, cmd_o}, 32'hEC);
        check("R8 drive_o", {24'h0, drive_o}, 32'hA0);

        // R4 32-bit read split
        data_in = 16'h1111;
        access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0);
        check("R4 first busy", {30'h0, busy, acc_done}, 32'h2);
        check("R4 first strobe", {28'h0, stb()}, 32'h4);
        data_in = 16'h2222;
        @(negedge clk);
        check("R4 second done", {30'h0, busy, acc_done}, 32'h1);
        check("R4 second strobe", {28'h0, stb()}, 32'h4);
        check("R4 word", acc_rdata, 32'h2222_1111);

        // R5 32-bit write split
        access(1'b1, 1'b0, 3'd0, 2'd2, 32'hCAFE_F00D);
        check("R5 low half", {16'h0, data_wr}, 32'hF00D);
        @(negedge clk);
        check("R5 high half", {16'h0, data_wr}, 32'hCAFE);
        check("R5 done strobe", {30'h0, acc_done, act_data}, 32'h3);

        // R11 external loads
        status_in = 8'h58; status_load = 1'b1;
        err_in = 8'h04; err_load = 1'b1;
        @(negedge clk);
        status_load = 1'b0; err_load = 1'b0;
        access(1'b0, 1'b1, 3'd6, 2'd0, 32'h0);
        check("R11 alt status", acc_rdata, 32'h58);
        check("R7 alt no strobe", {28'h0, stb()}, 32'h0);
        access(1'b0, 1'b0, 3'd1, 2'd0, 32'h0);
        check("R11 error", acc_rdata, 32'h04);

        // R12 interrupt
        intr_post = 1'b1;
        @(negedge clk);
        intr_post = 1'b0;
        check("R12 set", {24'h0, bm_status}, 32'h64);
        repeat (3) @(negedge clk);
        check("R12 sticky", {24'h0, bm_status}, 32'h64);

        // R1 reset restores
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 bm after reset", {24'h0, bm_status}, 32'h60);
        access(1'b0, 1'b1, 3'd6, 2'd0, 32'h0);
        check("R1 status after reset", acc_rdata, 32'h40);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule